// File: doc/BRIEF.md
# Two-Client Preemptive Quantum Bus Arbiter

This block shares one bus between a transmit engine and a receive engine. Each engine raises a request, waits for its grant, and either finishes and signals done or is preempted. Grants rotate in a round-robin manner. When the holder's time slice runs out and the other engine is waiting, the bus goes to the other engine. Each engine has its own slice length, set by a parameter. When both engines ask for an idle bus in the same cycle, the receive engine is served first.

Each grant is a registered output, so the grant signals change only on a rising clock edge. The bus is handed from one engine straight to the other on a single edge, with no idle cycle between them. If no one is waiting when the holder releases the bus, the arbiter goes idle.

Top module: `duplex_bus_arbiter`

## Requirements
- R1: The transmit grant and the receive grant are never high in the same cycle.
- R2: From idle, a lone requester is granted on the next rising edge. Without any request, both grants stay low.
- R3: From idle, when both clients request in the same cycle, the receive client is granted on the next edge.
- R4: The holder can release the bus with its done input. Its grant falls on the next edge. On that same edge the other client is granted if it is requesting; if it is not, the arbiter goes idle.
- R5: When the holder drops its request while granted, the arbiter acts exactly as if the holder had asserted done.
- R6: A holder's quantum expires on its Nth consecutive grant cycle. N is TX_QUANTUM for the transmit client and RX_QUANTUM for the receive client. If the other client is requesting in that cycle, the grant passes to it on the next edge. So while both clients keep requesting, the grants alternate in runs of exactly RX_QUANTUM and TX_QUANTUM cycles.
- R7: If the quantum expires while the other client is not requesting, the holder keeps the grant and starts a fresh full quantum.
- R8: A done pulse from the client that does not hold the grant has no effect on either grant.
- R9: A synchronous active-high reset clears both grants and returns the arbiter to idle by the next edge. The first tie after reset goes to the receive client.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Transmit client request |
| tx_done | input | 1 | Transmit client early release |
| rx_req | input | 1 | Receive client request |
| rx_done | input | 1 | Receive client early release |
| tx_grant | output | 1 | Registered grant to the transmit client |
| rx_grant | output | 1 | Registered grant to the receive client |

## Verification
The assertions assume that every input is a clean synchronous level sampled at the rising edge. They also assume that a done from a client that is not granted may appear at any time and must be harmless. They make no assumption that a client holds its request or pairs done with a request. The stimulus therefore varies all four inputs freely. Requests toggle with low probability, so both long holds (which reach expiry) and short ones appear. Done pulses are scattered regardless of who holds the grant. Directed phases pin down the tie, the handover, and the run lengths under continuous contention.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_TX   = 2'd1,
    OWN_RX   = 2'd2
  } owner_t;
endpackage

// File: rtl/slice_timer.sv
module slice_timer #(
  parameter int QUANTUM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic expire
);
  localparam int CW = (QUANTUM > 1) ? $clog2(QUANTUM) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUANTUM - 1);

  logic [CW-1:0] cnt;

  assign expire = active && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (expire)    cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // a new grant period always starts from an empty count
  assert_fresh_quantum_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |=> (cnt == '0));
endmodule

// File: rtl/grant_fsm.sv
module grant_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tx_req,
  input  logic tx_done,
  input  logic rx_req,
  input  logic rx_done,
  input  logic tx_expire,
  input  logic rx_expire,
  output logic tx_grant,
  output logic rx_grant
);
  owner_t own, own_nxt;
  logic tx_leave, rx_leave;

  assign tx_leave = tx_done || !tx_req || (tx_expire && rx_req);
  assign rx_leave = rx_done || !rx_req || (rx_expire && tx_req);

  always_comb begin
    own_nxt = own;
    unique case (own)
      OWN_NONE: begin
        if (rx_req)      own_nxt = OWN_RX;
        else if (tx_req) own_nxt = OWN_TX;
      end
      OWN_TX: if (tx_leave) own_nxt = rx_req ? OWN_RX : OWN_NONE;
      OWN_RX: if (rx_leave) own_nxt = tx_req ? OWN_TX : OWN_NONE;
      default: own_nxt = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own      <= OWN_NONE;
      tx_grant <= 1'b0;
      rx_grant <= 1'b0;
    end else begin
      own      <= own_nxt;
      tx_grant <= (own_nxt == OWN_TX);
      rx_grant <= (own_nxt == OWN_RX);
    end
  end

  assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_grant, rx_grant}));
  assert_tie_rx_R3: assert property (@(posedge clk) disable iff (rst)
    (!tx_grant && !rx_grant && rx_req) |=> rx_grant);
  assert_tx_release_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_grant && (tx_done || !tx_req)) |=> !tx_grant);
  assert_rx_release_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_grant && (rx_done || !rx_req)) |=> !rx_grant);
  assert_tx_preempt_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_grant && tx_expire && rx_req) |=> rx_grant);
  assert_rx_preempt_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_grant && rx_expire && tx_req) |=> tx_grant);
  assert_tx_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_grant && tx_req && !tx_done && !rx_req) |=> tx_grant);
  assert_rx_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_grant && rx_req && !rx_done && !tx_req) |=> rx_grant);
  assert_tx_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_grant) |-> $past(tx_req));
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (!tx_grant && !rx_grant));
endmodule

// File: rtl/duplex_bus_arbiter.sv
module duplex_bus_arbiter #(
  parameter int TX_QUANTUM = 6,
  parameter int RX_QUANTUM = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_req,
  input  logic tx_done,
  input  logic rx_req,
  input  logic rx_done,
  output logic tx_grant,
  output logic rx_grant
);
  localparam int NCLI = 2;

  logic [NCLI-1:0] held;
  logic [NCLI-1:0] expired;

  assign held = {rx_grant, tx_grant};

  for (genvar i = 0; i < NCLI; i++) begin : g_slice
    slice_timer #(
      .QUANTUM((i == 0) ? TX_QUANTUM : RX_QUANTUM)
    ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .active (held[i]),
      .expire (expired[i])
    );
  end

  grant_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tx_req    (tx_req),
    .tx_done   (tx_done),
    .rx_req    (rx_req),
    .rx_done   (rx_done),
    .tx_expire (expired[0]),
    .rx_expire (expired[1]),
    .tx_grant  (tx_grant),
    .rx_grant  (rx_grant)
  );
endmodule

// File: tb/duplex_bus_arbiter_test.sv
`timescale 1ns/1ps
module duplex_bus_arbiter_test;
  localparam int TXQ = 6;
  localparam int RXQ = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_req = 0, tx_done = 0, rx_req = 0, rx_done = 0;
  logic tx_grant, rx_grant;

  int n_chk = 0, n_fail = 0;
  int m_own = 0, m_cnt = 0;   // 0 idle, 1 tx, 2 rx
  int n_own, n_cnt;

  always #4 clk = ~clk;

  duplex_bus_arbiter #(.TX_QUANTUM(TXQ), .RX_QUANTUM(RXQ)) uut (
    .clk(clk), .rst(rst), .tx_req(tx_req), .tx_done(tx_done),
    .rx_req(rx_req), .rx_done(rx_done), .tx_grant(tx_grant), .rx_grant(rx_grant)
  );

  function automatic int pick_next(int own, int cnt, logic tr, logic td,
                                   logic rr, logic rd);
    logic texp, rexp;
    texp = (own == 1) && (cnt == TXQ - 1);
    rexp = (own == 2) && (cnt == RXQ - 1);
    case (own)
      1: return (td || !tr || (texp && rr)) ? (rr ? 2 : 0) : 1;
      2: return (rd || !rr || (rexp && tr)) ? (tr ? 1 : 0) : 2;
      default: return rr ? 2 : (tr ? 1 : 0);
    endcase
  endfunction

  function automatic int next_count(int own, int cnt, int nown);
    int q;
    q = (own == 1) ? TXQ : RXQ;
    if (own == 0 || nown != own) return 0;
    return (cnt == q - 1) ? 0 : cnt + 1;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp_v,
                       input string what);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  // inputs already set (between negedge and posedge); advance one edge and compare
  task automatic step(input string tag);
    if (rst) begin n_own = 0; n_cnt = 0; end
    else begin
      n_own = pick_next(m_own, m_cnt, tx_req, tx_done, rx_req, rx_done);
      n_cnt = next_count(m_own, m_cnt, n_own);
    end
    @(posedge clk); #1;
    m_own = n_own; m_cnt = n_cnt;
    check(tag, tx_grant, m_own == 1, "tx_grant");
    check(tag, rx_grant, m_own == 2, "rx_grant");
    check("R1", tx_grant & rx_grant, 1'b0, "both grants");
    @(negedge clk);
  endtask

  task automatic drive(input logic tr, input logic td, input logic rr, input logic rd);
    tx_req = tr; tx_done = td; rx_req = rr; rx_done = rd;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int run;
    void'($urandom(32'd2718));
    @(negedge clk);
    // R9 reset state
    drive(1, 0, 1, 0);
    step("R9");
    step("R9");
    rst = 0;
    // R2 no request keeps idle
    drive(0, 0, 0, 0); step("R2"); step("R2");
    // R3 tie from idle after reset
    drive(1, 0, 1, 0); step("R3");
    check("R3", rx_grant, 1'b1, "rx wins tie");
    // R4 rx done hands straight to tx
    drive(1, 0, 1, 1); step("R4");
    check("R4", tx_grant, 1'b1, "handover to tx");
    // R8 rx done while tx holds
    drive(1, 0, 0, 1); step("R8"); step("R8");
    check("R8", tx_grant, 1'b1, "tx kept after foreign done");
    // R7 tx alone runs past quantum
    drive(1, 0, 0, 0);
    for (int k = 0; k < 2 * TXQ + 3; k++) step("R7");
    check("R7", tx_grant, 1'b1, "tx kept past quantum");
    // R5 drop request while granted, other idle
    drive(0, 0, 0, 0); step("R5");
    check("R5", tx_grant, 1'b0, "dropped request releases");
    // R2 lone rx
    drive(0, 0, 1, 0); step("R2");
    check("R2", rx_grant, 1'b1, "lone rx granted");
    // R5 rx drops request with tx waiting
    drive(1, 0, 0, 0); step("R5");
    check("R5", tx_grant, 1'b1, "drop hands to tx");
    // R6 continuous contention: measure run lengths
    drive(1, 0, 1, 0);
    while (!rx_grant) step("R6");
    for (int r = 0; r < 3; r++) begin
      run = 0;
      while (rx_grant) begin run++; step("R6"); end
      n_chk++;
      if (run != RXQ) begin n_fail++; $display("FAIL R6 rx run: actual %0d expected %0d", run, RXQ); end
      run = 0;
      while (tx_grant) begin run++; step("R6"); end
      n_chk++;
      if (run != TXQ) begin n_fail++; $display("FAIL R6 tx run: actual %0d expected %0d", run, TXQ); end
    end
    // R9 mid-operation reset
    rst = 1; step("R9"); rst = 0;
    drive(1, 0, 1, 0); step("R9");
    check("R9", rx_grant, 1'b1, "rx preferred after reset");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(7) == 0) tx_req = ~tx_req;
      if ($urandom_range(7) == 0) rx_req = ~rx_req;
      tx_done = ($urandom_range(15) == 0);
      rx_done = ($urandom_range(15) == 0);
      rst = ($urandom_range(499) == 0);
      step("R4");
    end
    rst = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule